// File: doc/BRIEF.md
# Dual-Width Microprocessor Bus Port

This block sits between a character-display controller core and a slow asynchronous host bus. The bus has an enable strobe, a register-select line, a read/write line and an eight-bit data bus with a separate output enable. Every bus input is sampled into the controller clock domain through a two-flop synchroniser. A transfer is taken on the falling edge of the synchronised enable. Each completed byte gives the core a single-cycle pulse. Writes with select low are commands. Writes with select high are data. A read with select high is reported to the core so that it can step its address counter.

The port moves bytes either whole (8-bit mode) or as two nibbles on the upper four data lines, high nibble first. Any command whose top three bits are 001 loads the width from bit 4 of that command. The byte-wide mode is the reset state. A host can therefore send one 0010 nibble in byte-wide mode to enter nibble mode, and the following transfer starts with a high nibble. A status read returns the busy flag in the top bit and the address counter in the rest. In nibble mode that byte is split across two enable cycles.

The core-side outputs are plain valid pulses with no ready. The host bus cannot be stalled, so the core must accept each pulse in the cycle it appears. The host itself is expected to poll the busy flag.

Top module: `mpu_bus_port`

## Requirements
- R1: After reset, the port is in byte-wide mode with the nibble phase at high. No pulse is active and the bus output enable is low.
- R2: In byte-wide mode, a write with select low gives exactly one `cmd_valid` pulse carrying the whole data byte. The pulse is visible three clock cycles after the enable falls.
- R3: A write with select high gives exactly one `dat_valid` pulse carrying the byte. It does not give a command pulse.
- R4: A read with select low drives `{core_busy, core_addr}` on `bus_d_out`, with the busy flag on bit 7, while the enable is high.
- R5: A read with select high drives `core_rd_data` on the bus. When the byte completes it gives exactly one `rd_done` pulse.
- R6: `bus_d_oe` is high only while the synchronised read/write line is 1 (read) and the synchronised enable is high. It is low during writes and while the enable is low.
- R7: A command byte whose bits 7:5 are 001 sets the width from its bit 4: 1 selects byte-wide and 0 selects nibble mode. The new width applies from the next transfer.
- R8: In nibble mode a byte takes two enable cycles on data bits 7:4, high nibble first. No pulse follows the first cycle. Data bits 3:0 are ignored.
- R9: In nibble mode a read puts bits 7:4 of the selected byte on `bus_d_out[7:4]` in the first cycle and bits 3:0 in the second. `bus_d_out[3:0]` reads 0.
- R10: A single enable cycle in byte-wide mode carrying 0010 on bits 7:4 switches to nibble mode. The next enable cycle is taken as a high nibble.
- R11: At most one of `cmd_valid`, `dat_valid` and `rd_done` is high in any cycle. Each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Host enable strobe, asynchronous |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_d_in | input | 8 | Data bus as seen at the pads |
| bus_d_out | output | 8 | Read data to the pads |
| bus_d_oe | output | 1 | Pad output enable for the data bus |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Address counter from the core |
| core_rd_data | input | 8 | Data register contents for reads |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_byte | output | 8 | Command byte, valid with `cmd_valid` |
| dat_valid | output | 1 | One-cycle data write pulse |
| dat_byte | output | 8 | Data byte, valid with `dat_valid` |
| rd_done | output | 1 | One-cycle pulse when a data read completes |

## Verification
When the enable falls between clock edges, the drop reaches the second synchroniser flop on the second rising edge. The registered pulse follows on the third edge. A dedicated check samples the output after two edges, where it must still be low, and after three edges, where it must be high. Read data and the output enable appear two edges after the enable rises. The bench samples them on falling clock edges, four cycles into the enable-high window. Every other transfer holds the bus for five cycles after the enable drops before checking the pulse counters, which the bench updates on falling edges.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  // Synchronised bus sample: strobe plus qualifiers and data.
  typedef struct packed {
    logic              rs;
    logic              rw;
    logic [BYTE_W-1:0] d;
    logic              e;
  } bus_smp_t;

  localparam int unsigned SMP_W = $bits(bus_smp_t);

  // Command prefix that carries the width bit.
  localparam logic [2:0] WIDTH_CMD_PREFIX = 3'b001;
endpackage

// File: rtl/mpu_strobe_sync.sv
module mpu_strobe_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] smp_now,
  output logic [W-1:0] smp_last
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= raw_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_last <= '0;
    else        smp_last <= chain[STAGES-1];
  end

  assign smp_now = chain[STAGES-1];
endmodule

// File: rtl/mpu_nibble_seq.sv
module mpu_nibble_seq
  import mpu_bus_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              rs,
  input  logic              rw,
  input  logic [DATA_W-1:0] d,
  output logic              mode8,
  output logic              phase,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_byte,
  output logic              rd_done
);
  localparam int unsigned NW = DATA_W / 2;

  logic [NW-1:0]     hi_nib;
  logic              byte_done;
  logic [DATA_W-1:0] full_byte;

  assign byte_done = fall && (mode8 || phase);
  assign full_byte = mode8 ? d : {hi_nib, d[DATA_W-1 -: NW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode8     <= 1'b1;
      phase     <= 1'b0;
      hi_nib    <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      dat_valid <= 1'b0;
      dat_byte  <= '0;
      rd_done   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      dat_valid <= 1'b0;
      rd_done   <= 1'b0;
      if (fall && !mode8) begin
        phase <= ~phase;
        if (!phase) hi_nib <= d[DATA_W-1 -: NW];
      end
      if (byte_done) begin
        unique case ({rs, rw})
          2'b00: begin
            cmd_valid <= 1'b1;
            cmd_byte  <= full_byte;
            if (full_byte[DATA_W-1 -: 3] == WIDTH_CMD_PREFIX) begin
              mode8 <= full_byte[DATA_W-4];
              phase <= 1'b0;
            end
          end
          2'b10: begin
            dat_valid <= 1'b1;
            dat_byte  <= full_byte;
          end
          2'b11:   rd_done <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpu_read_mux.sv
module mpu_read_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AC_W   = 7
) (
  input  logic              mode8,
  input  logic              phase,
  input  logic              rs,
  input  logic              rw,
  input  logic              e_hi,
  input  logic              busy,
  input  logic [AC_W-1:0]   addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] d_out,
  output logic              oe
);
  localparam int unsigned NW = DATA_W / 2;

  logic [DATA_W-1:0] sel;
  logic [NW-1:0]     nib;

  assign sel   = rs ? rd_data : {busy, addr};
  assign nib   = phase ? sel[NW-1:0] : sel[DATA_W-1 -: NW];
  assign d_out = mode8 ? sel : {nib, {NW{1'b0}}};
  assign oe    = e_hi && rw;
endmodule

// File: rtl/mpu_bus_port.sv
module mpu_bus_port
  import mpu_bus_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned AC_W   = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_e,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [BYTE_W-1:0] bus_d_in,
  output logic [BYTE_W-1:0] bus_d_out,
  output logic              bus_d_oe,
  input  logic              core_busy,
  input  logic [AC_W-1:0]   core_addr,
  input  logic [BYTE_W-1:0] core_rd_data,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              dat_valid,
  output logic [BYTE_W-1:0] dat_byte,
  output logic              rd_done
);
  bus_smp_t raw, now_s, last_s;
  logic     fall, mode8, phase;

  assign raw = '{rs: bus_rs, rw: bus_rw, d: bus_d_in, e: bus_e};

  mpu_strobe_sync #(.W(SMP_W), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw),
    .smp_now  (now_s),
    .smp_last (last_s)
  );

  // Transfer edge: strobe was high in the previous sample, low now.
  assign fall = last_s.e && !now_s.e;

  mpu_nibble_seq #(.DATA_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .rs        (last_s.rs),
    .rw        (last_s.rw),
    .d         (last_s.d),
    .mode8     (mode8),
    .phase     (phase),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .dat_valid (dat_valid),
    .dat_byte  (dat_byte),
    .rd_done   (rd_done)
  );

  mpu_read_mux #(.DATA_W(BYTE_W), .AC_W(AC_W)) u_rmux (
    .mode8   (mode8),
    .phase   (phase),
    .rs      (now_s.rs),
    .rw      (now_s.rw),
    .e_hi    (now_s.e),
    .busy    (core_busy),
    .addr    (core_addr),
    .rd_data (core_rd_data),
    .d_out   (bus_d_out),
    .oe      (bus_d_oe)
  );
endmodule

// File: rtl/mpu_bus_port_chk.sv
module mpu_bus_port_chk #(
  parameter int unsigned STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_e,
  input logic       bus_rw,
  input logic       bus_d_oe,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       dat_valid,
  input logic       rd_done,
  input logic       mode8,
  input logic       phase
);
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, dat_valid, rd_done})); // R11
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2
  AST_DAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |=> !dat_valid); // R3
  AST_WIDTH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'b001) |-> (mode8 == cmd_byte[4])); // R7
  AST_BYTE_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mode8 |-> !phase); // R8

  if (STAGES == 2) begin : g_oe
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_d_oe |-> ($past(bus_e, 2) && $past(bus_rw, 2))); // R6
  end
endmodule

bind mpu_bus_port mpu_bus_port_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_e     (bus_e),
  .bus_rw    (bus_rw),
  .bus_d_oe  (bus_d_oe),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .dat_valid (dat_valid),
  .rd_done   (rd_done),
  .mode8     (mode8),
  .phase     (phase)
);

// File: tb/mpu_bus_port_test.sv
module mpu_bus_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_d_in = '0;
  logic [7:0] bus_d_out;
  logic       bus_d_oe;
  logic       core_busy = 1'b0;
  logic [6:0] core_addr = '0;
  logic [7:0] core_rd_data = '0;
  logic       cmd_valid, dat_valid, rd_done;
  logic [7:0] cmd_byte, dat_byte;

  int checks = 0, errors = 0;
  int n_cmd = 0, n_dat = 0, n_rd = 0;
  logic [7:0] last_cmd = '0, last_dat = '0;
  bit mode8_m = 1'b1;

  always #4 clk = ~clk;

  mpu_bus_port uut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .core_busy(core_busy), .core_addr(core_addr), .core_rd_data(core_rd_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .dat_valid(dat_valid),
    .dat_byte(dat_byte), .rd_done(rd_done)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin n_cmd++; last_cmd = cmd_byte; end
    if (dat_valid) begin n_dat++; last_dat = dat_byte; end
    if (rd_done) n_rd++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_nib(input logic [7:0] b, input bit second);
    return second ? {b[3:0], 4'h0} : {b[7:4], 4'h0};
  endfunction

  // One enable cycle; returns what the bus showed while the enable was high.
  task automatic bus_cycle(input bit rs, input bit rw, input logic [7:0] d,
                           output logic [7:0] seen, output logic seen_oe);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_d_in = d; bus_e = 1'b0;
    repeat (2) @(negedge clk);
    bus_e = 1'b1;
    repeat (4) @(negedge clk);
    seen = bus_d_out; seen_oe = bus_d_oe;
    bus_e = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic write_byte(input bit rs, input logic [7:0] b);
    logic [7:0] s; logic oe;
    int c0, d0;
    c0 = n_cmd; d0 = n_dat;
    if (mode8_m) begin
      bus_cycle(rs, 1'b0, b, s, oe);
      chk(!oe, "R6 oe during write", oe, 0);
    end else begin
      bus_cycle(rs, 1'b0, {b[7:4], 4'($urandom)}, s, oe);
      chk(n_cmd == c0 && n_dat == d0, "R8 no pulse after first nibble",
          n_cmd + n_dat, c0 + d0);
      bus_cycle(rs, 1'b0, {b[3:0], 4'($urandom)}, s, oe);
    end
    if (rs) begin
      chk(n_dat == d0 + 1 && last_dat == b, "R3 data write", last_dat, b);
      chk(n_cmd == c0, "R3 no command pulse", n_cmd, c0);
    end else begin
      chk(n_cmd == c0 + 1 && last_cmd == b, mode8_m ? "R2 command write" : "R8 nibble command",
          last_cmd, b);
      if (b[7:5] == 3'b001) mode8_m = b[4];
    end
    chk(bus_d_oe == 1'b0, "R6 oe low with enable low", bus_d_oe, 0);
  endtask

  task automatic read_byte(input bit rs);
    logic [7:0] s, exp; logic oe;
    int r0;
    r0 = n_rd;
    core_busy = 1'($urandom); core_addr = 7'($urandom); core_rd_data = 8'($urandom);
    exp = rs ? core_rd_data : {core_busy, core_addr};
    if (mode8_m) begin
      bus_cycle(rs, 1'b1, 8'($urandom), s, oe);
      chk(s == exp, rs ? "R5 data read value" : "R4 status read value", s, exp);
    end else begin
      bus_cycle(rs, 1'b1, 8'($urandom), s, oe);
      chk(s == exp_nib(exp, 1'b0), "R9 first read nibble", s, exp_nib(exp, 1'b0));
      bus_cycle(rs, 1'b1, 8'($urandom), s, oe);
      chk(s == exp_nib(exp, 1'b1), "R9 second read nibble", s, exp_nib(exp, 1'b1));
    end
    chk(oe, "R6 oe during read", oe, 1);
    chk(n_rd == r0 + (rs ? 1 : 0), "R5 read completion pulse", n_rd, r0 + (rs ? 1 : 0));
  endtask

  task automatic latency_check(input logic [7:0] b);
    @(negedge clk);
    bus_rs = 1'b0; bus_rw = 1'b0; bus_d_in = b; bus_e = 1'b0;
    repeat (2) @(negedge clk);
    bus_e = 1'b1;
    repeat (4) @(negedge clk);
    bus_e = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R2 no pulse after two edges", cmd_valid, 0);
    @(negedge clk);
    chk(cmd_valid == 1'b1 && cmd_byte == b, "R2 pulse after three edges", cmd_byte, b);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s; logic oe;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(bus_d_oe == 0 && cmd_valid == 0 && dat_valid == 0 && rd_done == 0,
        "R1 outputs in reset", {bus_d_oe, cmd_valid, dat_valid, rd_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_d_oe == 0 && cmd_valid == 0, "R1 idle after reset", {bus_d_oe, cmd_valid}, 0);
    latency_check(8'h01);
    chk(n_cmd == 1, "R1 byte-wide after reset", n_cmd, 1);
    write_byte(1'b1, 8'hA5);
    read_byte(1'b0);
    read_byte(1'b1);
    // Single 0010 nibble with junk on the low lines enters nibble mode.
    bus_cycle(1'b0, 1'b0, 8'h2B, s, oe);
    chk(last_cmd == 8'h2B, "R10 width command seen", last_cmd, 8'h2B);
    mode8_m = 1'b0;
    write_byte(1'b0, 8'h0F);
    chk(last_cmd == 8'h0F, "R10 next cycle is high nibble", last_cmd, 8'h0F);
    core_busy = 1'b1; core_addr = 7'h5A;
    bus_cycle(1'b0, 1'b1, 8'h00, s, oe);
    chk(s == 8'hD0, "R9 status high nibble with busy", s, 8'hD0);
    bus_cycle(1'b0, 1'b1, 8'h00, s, oe);
    chk(s == 8'hA0, "R9 status low nibble", s, 8'hA0);
    write_byte(1'b1, 8'h3C);
    write_byte(1'b0, 8'h38);
    chk(mode8_m == 1'b1, "R7 model back to byte-wide", mode8_m, 1);
    write_byte(1'b1, 8'h77);
    write_byte(1'b0, 8'h20);
    read_byte(1'b1);
    write_byte(1'b0, 8'h30);
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      case ($urandom % 4)
        0: write_byte(1'b0, b);
        1: write_byte(1'b1, b);
        2: read_byte(1'b0);
        default: read_byte(1'b1);
      endcase
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule